// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer with Bus Readout

This block is the digital core of a successive-approximation converter. A falling edge on the read/convert strobe starts a conversion, but only while the part is enabled and selected. The block then drives a trial code to an external DAC and reads back a one-bit comparator decision each cycle. It resolves the result from the most significant bit downward. A busy flag marks the conversion in progress, and start requests that arrive during that time are ignored.

The address bit sampled at the start sets the length of the run. Low selects a full 12-bit conversion. High selects a shortened 8-bit conversion that resolves only the upper eight bits. When the strobe is high and the block is idle, the result is presented in one of two forms. It can be a single 12-bit word. It can also be one of two left-justified bytes for an 8-bit bus, chosen by the address bit, where the low byte carries trailing zeros. Per-nibble enable flags take the place of three-state pads.

Top module: `sar_ctrl`

## Requirements
- R1: A conversion starts only on a clock edge where `chip_en` is 1, `sel_n` is 0, and `rdconv` is 0 after having been 1 at the previous edge. A strobe fall with `chip_en` at 0 or `sel_n` at 1 leaves `busy` at 0.
- R2: `busy` rises in the cycle after the start edge. It stays high for exactly 12 cycles in a full conversion and 8 cycles in a short one, then returns to 0.
- R3: A strobe fall while `busy` is 1 is ignored. It neither restarts nor lengthens the conversion, and it does not change the result.
- R4: A full conversion keeps each trial bit when `cmp_hi` is 1, meaning the input is at or above the trial code. For an input v in 0..4095 the result equals v.
- R5: A short conversion resolves bits 11..4 only. Bits 3..0 of the trial code and of the result are 0, so the result for input v is v with its low four bits cleared.
- R6: The length selected by `addr_bit` at the start edge holds for the whole conversion, even if `addr_bit` changes during it.
- R7: `data_oe` is nonzero only while `chip_en` is 1, `sel_n` is 0, `rdconv` is 1 and `busy` is 0. Whenever all of `data_oe` is 0, `data_out` is 0.
- R8: With `wide_sel` at 1, a read drives the whole 12-bit result on `data_out`, and `data_oe` is 3'b111.
- R9: With `wide_sel` at 0, a read drives `data_out[11:4]`. With `addr_bit` at 0 it carries result bits 11..4. With `addr_bit` at 1 it carries result bits 3..0 in `data_out[11:8]` and zeros in `data_out[7:4]`. `data_out[3:0]` is 0 and `data_oe` is 3'b110 in both cases.
- R10: In the first busy cycle the trial code is 12'h800, with only the MSB set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| chip_en | input | 1 | Active-high enable |
| sel_n | input | 1 | Active-low select |
| rdconv | input | 1 | Read (high) / convert on falling edge |
| addr_bit | input | 1 | Length select at start; byte select on reads |
| wide_sel | input | 1 | 1: 12-bit word read; 0: left-justified byte reads |
| cmp_hi | input | 1 | Comparator: 1 when the input is at or above the trial code |
| trial_code | output | 12 | Trial code to the DAC |
| busy | output | 1 | Conversion in progress |
| data_out | output | 12 | Read data |
| data_oe | output | 3 | Per-nibble drive enables, bit n covers data_out[4n+3:4n] |

## Verification
A wrong bit index or a wrong keep/clear decision in the approximation register corrupts the result word. That error shows at the very next read after `busy` falls. A full sweep of all 4096 inputs exposes every bit position. A wrong stop index or a length latch that is not held moves the falling edge of `busy` by at least one cycle, and the bench counts that cycle by cycle. A broken lockout or start detector shows as a changed busy length, a stuck `busy`, or `busy` rising on a disabled strobe within one cycle.

// File: rtl/sar_pkg.sv
package sar_pkg;
  typedef enum logic [1:0] {
    RD_WORD    = 2'd0,
    RD_BYTE_HI = 2'd1,
    RD_BYTE_LO = 2'd2
  } rd_fmt_e;
endpackage

// File: rtl/sar_rst_sync.sv
module sar_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_s
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_s = sync_q[1];
endmodule

// File: rtl/sar_start_ctl.sv
module sar_start_ctl (
  input  logic clk,
  input  logic rst_s,
  input  logic chip_en,
  input  logic sel_n,
  input  logic rdconv,
  input  logic addr_bit,
  input  logic done,
  output logic start,
  output logic busy,
  output logic short_q
);
  logic strobe_q;
  logic busy_q, busy_d;
  logic short_r, short_d;

  // falling strobe, enabled and selected, and nothing in flight
  assign start = chip_en & ~sel_n & strobe_q & ~rdconv & ~busy_q;

  always_comb begin
    busy_d  = busy_q;
    short_d = short_r;
    if (start) begin
      busy_d  = 1'b1;
      short_d = addr_bit;
    end else if (done) begin
      busy_d  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      strobe_q <= 1'b1;
      busy_q   <= 1'b0;
      short_r  <= 1'b0;
    end else begin
      strobe_q <= rdconv;
      busy_q   <= busy_d;
      short_r  <= short_d;
    end
  end

  assign busy    = busy_q;
  assign short_q = short_r;
endmodule

// File: rtl/sar_engine.sv
module sar_engine #(
  parameter int unsigned W     = 12,
  parameter int unsigned SHORT = 8
) (
  input  logic         clk,
  input  logic         rst_s,
  input  logic         start,
  input  logic         busy,
  input  logic         short_q,
  input  logic         cmp_hi,
  output logic [W-1:0] trial,
  output logic [W-1:0] result,
  output logic         done
);
  localparam int unsigned IDXW = $clog2(W);

  logic [W-1:0]    trial_q, trial_d;
  logic [W-1:0]    result_q, result_d;
  logic [W-1:0]    decided;
  logic [IDXW-1:0] idx_q, idx_d, idx_dn, last_idx;

  assign last_idx = short_q ? IDXW'(W - SHORT) : '0;
  assign idx_dn   = idx_q - 1'b1;

  always_comb begin
    decided = trial_q;
    if (!cmp_hi) decided[idx_q] = 1'b0;
  end

  always_comb begin
    trial_d  = trial_q;
    result_d = result_q;
    idx_d    = idx_q;
    done     = 1'b0;
    if (start) begin
      trial_d        = '0;
      trial_d[W-1]   = 1'b1;
      idx_d          = IDXW'(W - 1);
    end else if (busy) begin
      if (idx_q == last_idx) begin
        done     = 1'b1;
        trial_d  = decided;
        result_d = decided;
      end else begin
        trial_d         = decided;
        trial_d[idx_dn] = 1'b1;
        idx_d           = idx_dn;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      trial_q  <= '0;
      result_q <= '0;
      idx_q    <= '0;
    end else begin
      trial_q  <= trial_d;
      result_q <= result_d;
      idx_q    <= idx_d;
    end
  end

  assign trial  = trial_q;
  assign result = result_q;
endmodule

// File: rtl/sar_readout.sv
module sar_readout
  import sar_pkg::*;
#(
  parameter int unsigned W    = 12,
  parameter int unsigned BYTE = 8
) (
  input  logic           chip_en,
  input  logic           sel_n,
  input  logic           rdconv,
  input  logic           busy,
  input  logic           addr_bit,
  input  logic           wide_sel,
  input  logic [W-1:0]   result,
  output logic [W-1:0]   data_out,
  output logic [W/4-1:0] data_oe
);
  localparam int unsigned NIB    = W / 4;
  localparam int unsigned HI_NIB = BYTE / 4;
  localparam int unsigned LOW    = W - BYTE;

  rd_fmt_e fmt;
  logic    rd_on;

  assign rd_on = chip_en & ~sel_n & rdconv & ~busy;

  always_comb begin
    if (wide_sel)      fmt = RD_WORD;
    else if (addr_bit) fmt = RD_BYTE_LO;
    else               fmt = RD_BYTE_HI;
  end

  always_comb begin
    data_out = '0;
    if (rd_on) begin
      unique case (fmt)
        RD_WORD:    data_out = result;
        RD_BYTE_HI: data_out = {result[W-1 -: BYTE], {LOW{1'b0}}};
        RD_BYTE_LO: data_out = {result[LOW-1:0], {(W-LOW){1'b0}}};
        default:    data_out = '0;
      endcase
    end
  end

  for (genvar n = 0; n < NIB; n++) begin : g_oe
    if (n >= NIB - HI_NIB) begin : g_top
      assign data_oe[n] = rd_on;
    end else begin : g_low
      assign data_oe[n] = rd_on & wide_sel;
    end
  end
endmodule

// File: rtl/sar_ctrl.sv
module sar_ctrl #(
  parameter int unsigned W     = 12,
  parameter int unsigned SHORT = 8,
  parameter int unsigned BYTE  = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           chip_en,
  input  logic           sel_n,
  input  logic           rdconv,
  input  logic           addr_bit,
  input  logic           wide_sel,
  input  logic           cmp_hi,
  output logic [W-1:0]   trial_code,
  output logic           busy,
  output logic [W-1:0]   data_out,
  output logic [W/4-1:0] data_oe
);
  logic         rst_s;
  logic         start, done, short_q;
  logic [W-1:0] result;

  sar_rst_sync u_rst (
    .clk   (clk),
    .rst_n (rst_n),
    .rst_s (rst_s)
  );

  sar_start_ctl u_ctl (
    .clk      (clk),
    .rst_s    (rst_s),
    .chip_en  (chip_en),
    .sel_n    (sel_n),
    .rdconv   (rdconv),
    .addr_bit (addr_bit),
    .done     (done),
    .start    (start),
    .busy     (busy),
    .short_q  (short_q)
  );

  sar_engine #(.W(W), .SHORT(SHORT)) u_eng (
    .clk     (clk),
    .rst_s   (rst_s),
    .start   (start),
    .busy    (busy),
    .short_q (short_q),
    .cmp_hi  (cmp_hi),
    .trial   (trial_code),
    .result  (result),
    .done    (done)
  );

  sar_readout #(.W(W), .BYTE(BYTE)) u_rd (
    .chip_en  (chip_en),
    .sel_n    (sel_n),
    .rdconv   (rdconv),
    .busy     (busy),
    .addr_bit (addr_bit),
    .wide_sel (wide_sel),
    .result   (result),
    .data_out (data_out),
    .data_oe  (data_oe)
  );
endmodule

// File: rtl/sar_chk.sv
module sar_chk #(
  parameter int unsigned W     = 12,
  parameter int unsigned SHORT = 8
) (
  input logic           clk,
  input logic           rst_s,
  input logic           chip_en,
  input logic           sel_n,
  input logic           rdconv,
  input logic           wide_sel,
  input logic           busy,
  input logic           short_q,
  input logic [W-1:0]   trial_code,
  input logic [W-1:0]   data_out,
  input logic [W/4-1:0] data_oe
);
  logic [7:0] run_len;

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s)    run_len <= '0;
    else if (busy) run_len <= 8'(run_len + 1'b1);
    else           run_len <= '0;
  end

  AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_s)
    (chip_en && !sel_n && $fell(rdconv) && !busy) |=> busy); // R1
  AST_BUSY_SPAN: assert property (@(posedge clk) disable iff (!rst_s)
    busy |-> (run_len < W)); // R2
  AST_MODE_HOLD: assert property (@(posedge clk) disable iff (!rst_s)
    (busy && $past(busy)) |-> $stable(short_q)); // R6
  AST_OE_IDLE: assert property (@(posedge clk) disable iff (!rst_s)
    busy |-> (data_oe == '0)); // R7
  AST_SHORT_LSB: assert property (@(posedge clk) disable iff (!rst_s)
    (busy && short_q) |-> (trial_code[W-SHORT-1:0] == '0)); // R5
  AST_BYTE_TAIL: assert property (@(posedge clk) disable iff (!rst_s)
    !wide_sel |-> (!data_oe[0] && data_out[3:0] == 4'h0)); // R9
  AST_FIRST_TRIAL: assert property (@(posedge clk) disable iff (!rst_s)
    $rose(busy) |-> (trial_code == {1'b1, {(W-1){1'b0}}})); // R10
endmodule

bind sar_ctrl sar_chk #(.W(W), .SHORT(SHORT)) u_chk (
  .clk        (clk),
  .rst_s      (rst_s),
  .chip_en    (chip_en),
  .sel_n      (sel_n),
  .rdconv     (rdconv),
  .wide_sel   (wide_sel),
  .busy       (busy),
  .short_q    (short_q),
  .trial_code (trial_code),
  .data_out   (data_out),
  .data_oe    (data_oe)
);

// File: tb/sim_sar_ctrl.sv
`timescale 1ns/1ps
module sim_sar_ctrl;
  logic        clk = 1'b0;
  logic        rst_n, chip_en, sel_n, rdconv, addr_bit, wide_sel;
  logic        cmp_hi;
  logic [11:0] trial_code, data_out, vin;
  logic        busy;
  logic [2:0]  data_oe;
  int          n_chk = 0;
  int          n_bad = 0;
  bit          finished = 0;

  always #2 clk = ~clk;

  assign cmp_hi = (vin >= trial_code);

  sar_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .chip_en(chip_en), .sel_n(sel_n),
    .rdconv(rdconv), .addr_bit(addr_bit), .wide_sel(wide_sel),
    .cmp_hi(cmp_hi), .trial_code(trial_code), .busy(busy),
    .data_out(data_out), .data_oe(data_oe)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // one conversion followed by word and byte reads
  task automatic convert(input logic [11:0] v, input bit shrt, input bit glitch);
    int cycles;
    logic [11:0] exp;
    exp = shrt ? (v & 12'hFF0) : v;
    vin = v; addr_bit = shrt; wide_sel = 1'b1;
    @(negedge clk) rdconv = 1'b0;
    @(negedge clk);
    chk("R10 first trial", int'(trial_code), 12'h800);
    cycles = 0;
    while (busy && cycles < 40) begin
      cycles++;
      if (glitch && cycles == 3) begin
        rdconv = 1'b1; addr_bit = ~shrt;
        #1 chk("R7 oe off while busy", int'(data_oe), 0);
      end
      if (glitch && cycles == 4) rdconv = 1'b0;
      @(negedge clk);
    end
    chk(shrt ? "R5 short length" : "R2 full length", cycles, shrt ? 8 : 12);
    if (glitch) chk("R3 R6 lockout length", cycles, shrt ? 8 : 12);
    chk("R7 oe off with strobe low", int'(data_oe), 0);
    chk("R7 data zero when off", int'(data_out), 0);
    rdconv = 1'b1; wide_sel = 1'b1;
    #1;
    chk(shrt ? "R5 short result" : "R4 full result", int'(data_out), int'(exp));
    chk("R8 word oe", int'(data_oe), 3'b111);
    wide_sel = 1'b0; addr_bit = 1'b0;
    #1;
    chk("R9 high byte", int'(data_out), int'({exp[11:4], 4'h0}));
    chk("R9 byte oe", int'(data_oe), 3'b110);
    addr_bit = 1'b1;
    #1;
    chk("R9 low byte", int'(data_out), int'({exp[3:0], 8'h00}));
    wide_sel = 1'b1; addr_bit = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; chip_en = 1'b0; sel_n = 1'b1; rdconv = 1'b1;
    addr_bit = 1'b0; wide_sel = 1'b1; vin = '0;
    repeat (3) @(negedge clk);
    chk("R2 reset busy", int'(busy), 0);
    chk("R7 reset oe", int'(data_oe), 0);
    chk("R7 reset data", int'(data_out), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: disabled or deselected strobe falls do not start
    sel_n = 1'b0;
    rdconv = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 chip_en low no start", int'(busy), 0);
    rdconv = 1'b1; #1 chk("R7 chip_en low oe off", int'(data_oe), 0);
    chip_en = 1'b1; sel_n = 1'b1;
    @(negedge clk) rdconv = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 sel_n high no start", int'(busy), 0);
    rdconv = 1'b1; sel_n = 1'b0;
    @(negedge clk);

    for (int v = 0; v < 4096; v++) convert(12'(v), 1'b0, 1'b0);
    for (int v = 0; v < 4096; v += 7) convert(12'(v), 1'b1, 1'b0);
    convert(12'hA5C, 1'b0, 1'b1);
    convert(12'h3E7, 1'b1, 1'b1);
    convert(12'hFFF, 1'b0, 1'b1);
    convert(12'h001, 1'b1, 1'b1);

    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #(200000 * 4);
    if (!finished) begin
      finished = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule